// File: doc/BRIEF.md
# Counter clock and gate source router

This block sits in front of two (by default) groups of three counter channels. For every channel it picks the signal used as the counter's clock enable and the signal used as its gate. Two 5-bit selection registers per channel, one for the clock and one for the gate, are written and read over a small single-cycle register bus. Clock candidates are the channel's own external pin, a shared external clock per group, enables from an internal divider chain, constant levels, the pattern-present input, and the output of the channel before it. Gate candidates are constant levels, the channel's own gate pin, the output of a channel two places before it, and three pattern status signals, each also in negated form.

The counter outputs come back into the block as inputs. This lets a channel clock or gate from another channel, and the channels form a ring across groups. An enhanced-mode input unlocks the extended codes. The block also drives the output enable of every channel's external clock and gate pins, because any selection that does not use a pin turns that pin into an output. All routing is combinational from the current register values and inputs. The divider chain and the pattern latches are clocked by the 20 MHz reference, which is the block clock.

Top module: `ctr_src_router`

## Requirements
- R1: With clock code 0 a channel's clock route follows its own clock pin. Code 6 follows the output of the preceding channel. Code 7 follows its group's shared external clock. Codes 1 to 5 follow the internal enables of R2, with code 1 the fastest.
- R2: Counting block clock edges since reset release as n, the internal enables are single-cycle pulses. The pulse for code k (1..5) is high exactly when n mod (2·10^(k-1)) equals that period minus one.
- R3: In enhanced mode, clock codes 8 and 11 give a constant high (11 is the full-rate enable), 9 gives low, and 10 follows pattern-present. In basic mode codes 8 to 31 give low, and in either mode codes 12 to 31 give low.
- R4: Gate code 0 gives high, 1 gives low, 2 follows the channel's gate pin, and 3 gives the inverse of the output of the channel two places before.
- R5: In enhanced mode, gate code 6 is the inverted gate pin and 7 is the non-inverted output two places before. Codes 8, 9 and 10 give pattern-present, pattern-occurred and pattern-gone-away, and 11, 12 and 13 give their inverses. All other gate codes, and codes 6 to 13 in basic mode, give low.
- R6: Channels are numbered group·3+position. The clock neighbour of position 0 is position 2 of the preceding group, and for other positions it is the previous position. The gate neighbour of position 2 is position 0 of the same group, and for positions 0 and 1 it is position+1 of the preceding group. Group 0 is preceded by the highest group.
- R7: A channel's clock pin output enable is high exactly when its clock code is not 0. Its gate pin output enable is high exactly when its gate code is not 2.
- R8: Pattern-occurred rises on the edge after a rising pattern-present. Pattern-gone-away starts high and falls on the edge after pattern-present drops while occurred is set. The clear strobe sets occurred low and gone-away high on the next edge, and it takes priority.
- R9: The address is {gate select bit 3, channel bits 2:0}. A write stores wdata in the addressed register, and readback returns the last value written. Channel fields of 6 and above read as 0, and writes to them change no register.
- R10: Reset sets all selection registers to 0, both pattern latches to their idle values, and the divider chain to its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference, block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | {gate select, channel index} |
| wdata | input | 5 | Write data (source code) |
| rdata | output | 5 | Readback of the addressed register |
| enhanced | input | 1 | Enables the extended code set |
| patPresent | input | 1 | Pattern detector present level |
| patClr | input | 1 | Clears both pattern latches |
| clkPin | input | 6 | Per-channel external clock pin level |
| gatePin | input | 6 | Per-channel external gate pin level |
| extClk | input | 2 | Per-group shared external clock |
| ctrOut | input | 6 | Counter channel outputs |
| ctrClk | output | 6 | Routed clock enable per channel |
| ctrGate | output | 6 | Routed gate per channel |
| clkPinOe | output | 6 | Clock pin drives out when high |
| gatePinOe | output | 6 | Gate pin drives out when high |

## Verification
On every cycle the assertions hold the pin output enables to the code just written and the readback to the last write. They also require that the divider pulses nest, that gone-away never drops without occurred set, and that the clear strobe restores both latches. The full code-to-source mapping in both modes, the ring wrap of neighbour channels across groups, and the exact pulse phase of the slow divider taps can only be shown by the bench. It sweeps every code against a behavioural model and runs tens of thousands of cycles for the 1 kHz tap.

// File: rtl/ctr_src_pkg.sv
package ctr_src_pkg;
  localparam int NUM_TICK = 5;
  localparam int GRP_CH = 3;

  typedef enum logic [4:0] {
    CK_PIN = 5'd0, CK_T0 = 5'd1, CK_T1 = 5'd2, CK_T2 = 5'd3, CK_T3 = 5'd4,
    CK_T4 = 5'd5, CK_PREV = 5'd6, CK_GRPEXT = 5'd7, CK_HIGH = 5'd8,
    CK_LOW = 5'd9, CK_PAT = 5'd10, CK_FULL = 5'd11
  } clkCode_e;

  typedef enum logic [4:0] {
    GT_ON = 5'd0, GT_OFF = 5'd1, GT_PIN = 5'd2, GT_NPREV2 = 5'd3,
    GT_NPIN = 5'd6, GT_PREV2 = 5'd7, GT_PAT = 5'd8, GT_OCC = 5'd9,
    GT_GONE = 5'd10, GT_NPAT = 5'd11, GT_NOCC = 5'd12, GT_NGONE = 5'd13
  } gateCode_e;

  typedef struct packed {
    logic [NUM_TICK-1:0] tick;
    logic patNow;
    logic patOcc;
    logic patGone;
  } srcStrobe_t;
endpackage

// File: rtl/ctr_src_ctrl.sv
module ctr_src_ctrl
  import ctr_src_pkg::*;
#(
  parameter int NCH = 6,
  parameter int SEL_W = 5,
  parameter int ADDR_W = 4,
  parameter int DIV_FIRST = 2,
  parameter int DIV_STEP = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] rdata,
  input  logic patPresent,
  input  logic patClr,
  output logic [NCH-1:0][SEL_W-1:0] clkSel,
  output logic [NCH-1:0][SEL_W-1:0] gateSel,
  output srcStrobe_t strb
);
  localparam int CH_W = ADDR_W - 1;

  logic [CH_W-1:0] chIdx;
  logic isGate;
  logic hit;
  assign chIdx = addr[CH_W-1:0];
  assign isGate = addr[ADDR_W-1];
  assign hit = int'(chIdx) < NCH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel <= '0;
      gateSel <= '0;
    end else if (wrEn && hit) begin
      for (int i = 0; i < NCH; i++) begin
        if (chIdx == CH_W'(i)) begin
          if (isGate) gateSel[i] <= wdata;
          else        clkSel[i]  <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chIdx == CH_W'(i)) rdata = isGate ? gateSel[i] : clkSel[i];
    end
  end

  // Cascaded divider: stage 0 divides the reference, later stages divide the previous tap.
  logic [NUM_TICK-1:0] tickW;
  for (genvar k = 0; k < NUM_TICK; k++) begin : gDiv
    localparam int D = (k == 0) ? DIV_FIRST : DIV_STEP;
    localparam int CW = (D > 2) ? $clog2(D) : 1;
    logic [CW-1:0] cnt;
    logic adv;
    if (k == 0) begin : gBase
      assign adv = 1'b1;
    end else begin : gChain
      assign adv = tickW[k-1];
    end
    assign tickW[k] = adv && (cnt == CW'(D - 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cnt <= '0;
      else if (adv) cnt <= (cnt == CW'(D - 1)) ? '0 : cnt + 1'b1;
    end
  end

  logic patPrev, occQ, goneQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patPrev <= 1'b0;
      occQ <= 1'b0;
      goneQ <= 1'b1;
    end else begin
      patPrev <= patPresent;
      if (patClr) begin
        occQ <= 1'b0;
        goneQ <= 1'b1;
      end else begin
        if (patPresent && !patPrev) occQ <= 1'b1;
        if (occQ && patPrev && !patPresent) goneQ <= 1'b0;
      end
    end
  end

  assign strb.tick = tickW;
  assign strb.patNow = patPresent;
  assign strb.patOcc = occQ;
  assign strb.patGone = goneQ;
endmodule

// File: rtl/ctr_src_datapath.sv
module ctr_src_datapath
  import ctr_src_pkg::*;
#(
  parameter int NGRP = 2,
  parameter int SEL_W = 5,
  localparam int NCH = NGRP * GRP_CH
) (
  input  logic [NCH-1:0][SEL_W-1:0] clkSel,
  input  logic [NCH-1:0][SEL_W-1:0] gateSel,
  input  srcStrobe_t strb,
  input  logic enhanced,
  input  logic [NCH-1:0] clkPin,
  input  logic [NCH-1:0] gatePin,
  input  logic [NGRP-1:0] extClk,
  input  logic [NCH-1:0] ctrOut,
  output logic [NCH-1:0] ctrClk,
  output logic [NCH-1:0] ctrGate,
  output logic [NCH-1:0] clkPinOe,
  output logic [NCH-1:0] gatePinOe
);
  for (genvar i = 0; i < NCH; i++) begin : gCh
    localparam int G = i / GRP_CH;
    localparam int C = i % GRP_CH;
    localparam int PG = (G + NGRP - 1) % NGRP;
    localparam int NB1 = (C > 0) ? i - 1 : PG * GRP_CH + 2;
    localparam int NB2 = (C == 2) ? G * GRP_CH : PG * GRP_CH + C + 1;
    logic clkV, gateV;

    always_comb begin
      case (clkSel[i])
        CK_PIN:    clkV = clkPin[i];
        CK_T0:     clkV = strb.tick[0];
        CK_T1:     clkV = strb.tick[1];
        CK_T2:     clkV = strb.tick[2];
        CK_T3:     clkV = strb.tick[3];
        CK_T4:     clkV = strb.tick[4];
        CK_PREV:   clkV = ctrOut[NB1];
        CK_GRPEXT: clkV = extClk[G];
        CK_HIGH:   clkV = enhanced;
        CK_PAT:    clkV = enhanced & strb.patNow;
        CK_FULL:   clkV = enhanced;
        default:   clkV = 1'b0;
      endcase
    end

    always_comb begin
      case (gateSel[i])
        GT_ON:     gateV = 1'b1;
        GT_OFF:    gateV = 1'b0;
        GT_PIN:    gateV = gatePin[i];
        GT_NPREV2: gateV = ~ctrOut[NB2];
        GT_NPIN:   gateV = enhanced & ~gatePin[i];
        GT_PREV2:  gateV = enhanced & ctrOut[NB2];
        GT_PAT:    gateV = enhanced & strb.patNow;
        GT_OCC:    gateV = enhanced & strb.patOcc;
        GT_GONE:   gateV = enhanced & strb.patGone;
        GT_NPAT:   gateV = enhanced & ~strb.patNow;
        GT_NOCC:   gateV = enhanced & ~strb.patOcc;
        GT_NGONE:  gateV = enhanced & ~strb.patGone;
        default:   gateV = 1'b0;
      endcase
    end

    assign ctrClk[i] = clkV;
    assign ctrGate[i] = gateV;
    assign clkPinOe[i] = clkSel[i] != SEL_W'(CK_PIN);
    assign gatePinOe[i] = gateSel[i] != SEL_W'(GT_PIN);
  end
endmodule

// File: rtl/ctr_src_router.sv
module ctr_src_router
  import ctr_src_pkg::*;
#(
  parameter int NGRP = 2,
  parameter int SEL_W = 5,
  parameter int DIV_FIRST = 2,
  parameter int DIV_STEP = 10,
  localparam int NCH = NGRP * GRP_CH,
  localparam int ADDR_W = $clog2(NCH) + 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] rdata,
  input  logic enhanced,
  input  logic patPresent,
  input  logic patClr,
  input  logic [NCH-1:0] clkPin,
  input  logic [NCH-1:0] gatePin,
  input  logic [NGRP-1:0] extClk,
  input  logic [NCH-1:0] ctrOut,
  output logic [NCH-1:0] ctrClk,
  output logic [NCH-1:0] ctrGate,
  output logic [NCH-1:0] clkPinOe,
  output logic [NCH-1:0] gatePinOe
);
  logic [NCH-1:0][SEL_W-1:0] clkSel, gateSel;
  srcStrobe_t strb;

  ctr_src_ctrl #(
    .NCH(NCH), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .DIV_FIRST(DIV_FIRST), .DIV_STEP(DIV_STEP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .patPresent(patPresent), .patClr(patClr),
    .clkSel(clkSel), .gateSel(gateSel), .strb(strb)
  );

  ctr_src_datapath #(.NGRP(NGRP), .SEL_W(SEL_W)) uDp (
    .clkSel(clkSel), .gateSel(gateSel), .strb(strb), .enhanced(enhanced),
    .clkPin(clkPin), .gatePin(gatePin), .extClk(extClk), .ctrOut(ctrOut),
    .ctrClk(ctrClk), .ctrGate(ctrGate), .clkPinOe(clkPinOe),
    .gatePinOe(gatePinOe)
  );
endmodule

// File: rtl/ctr_src_router_chk.sv
module ctr_src_router_chk
  import ctr_src_pkg::*;
#(
  parameter int NGRP = 2,
  parameter int SEL_W = 5,
  localparam int NCH = NGRP * GRP_CH,
  localparam int ADDR_W = $clog2(NCH) + 1
) (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [SEL_W-1:0] wdata,
  input logic [SEL_W-1:0] rdata,
  input logic patClr,
  input logic [NCH-1:0] clkPinOe,
  input logic [NCH-1:0] gatePinOe,
  input srcStrobe_t strb
);
  localparam int CH_W = ADDR_W - 1;

  for (genvar i = 0; i < NCH; i++) begin : gOe
    // R7: clock pin direction follows the code just written
    a_r7_clk_oe: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !addr[ADDR_W-1] && addr[CH_W-1:0] == CH_W'(i))
      |=> (clkPinOe[i] == ($past(wdata) != '0)));
    // R7: gate pin direction follows the code just written
    a_r7_gate_oe: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr[ADDR_W-1] && addr[CH_W-1:0] == CH_W'(i))
      |=> (gatePinOe[i] == ($past(wdata) != SEL_W'(2))));
  end

  // R9: readback of a mapped register returns the value just written
  a_r9_readback: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr[CH_W-1:0]) < NCH)
    |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

  // R8: gone-away can only be low once occurred has been set
  a_r8_gone_needs_occ: assert property (@(posedge clk) disable iff (!rstN)
    !strb.patGone |-> strb.patOcc);

  // R8: clear strobe restores both latches on the next edge
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    patClr |=> (strb.patGone && !strb.patOcc));

  for (genvar k = 1; k < NUM_TICK; k++) begin : gTick
    // R2: a slower divider tap only pulses together with the faster one
    a_r2_nested: assert property (@(posedge clk) disable iff (!rstN)
      strb.tick[k] |-> strb.tick[k-1]);
  end
endmodule

bind ctr_src_router ctr_src_router_chk #(.NGRP(NGRP), .SEL_W(SEL_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .rdata(rdata), .patClr(patClr), .clkPinOe(clkPinOe),
  .gatePinOe(gatePinOe), .strb(strb)
);

// File: tb/tb_ctr_src_router.sv
`timescale 1ns/1ps
module tb_ctr_src_router;
  localparam int NG = 2;
  localparam int NC = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [4:0] wdata = '0;
  logic [4:0] rdata;
  logic enhanced = 1'b0, patPresent = 1'b0, patClr = 1'b0;
  logic [NC-1:0] clkPin = '0, gatePin = '0, ctrOut = '0;
  logic [NG-1:0] extClk = '0;
  logic [NC-1:0] ctrClk, ctrGate, clkPinOe, gatePinOe;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctr_src_router dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .enhanced(enhanced), .patPresent(patPresent),
    .patClr(patClr), .clkPin(clkPin), .gatePin(gatePin), .extClk(extClk),
    .ctrOut(ctrOut), .ctrClk(ctrClk), .ctrGate(ctrGate),
    .clkPinOe(clkPinOe), .gatePinOe(gatePinOe)
  );

  // Behavioural reference state
  int mClk[NC];
  int mGate[NC];
  longint cyc;
  bit mOcc, mGone, mPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (mClk[i]) begin mClk[i] = 0; mGate[i] = 0; end
      cyc = 0; mOcc = 0; mGone = 1; mPrev = 0;
    end else begin
      bit nOcc, nGone;
      nOcc = mOcc; nGone = mGone;
      if (wrEn && addr[2:0] < 6) begin
        if (addr[3]) mGate[addr[2:0]] = wdata;
        else mClk[addr[2:0]] = wdata;
      end
      if (patClr) begin nOcc = 0; nGone = 1; end
      else begin
        if (patPresent && !mPrev) nOcc = 1;
        if (mOcc && mPrev && !patPresent) nGone = 0;
      end
      mOcc = nOcc; mGone = nGone; mPrev = patPresent;
      cyc = cyc + 1;
    end
  end

  function automatic bit tickAt(int k);
    longint p = 2;
    for (int j = 1; j < k; j++) p = p * 10;
    return (cyc % p) == p - 1;
  endfunction

  function automatic int nb1(int i);  // R6 clock neighbour
    int g = i / 3, c = i % 3, pg = (i / 3 + NG - 1) % NG;
    return (c > 0) ? g * 3 + c - 1 : pg * 3 + 2;
  endfunction

  function automatic int nb2(int i);  // R6 gate neighbour
    int g = i / 3, c = i % 3, pg = (i / 3 + NG - 1) % NG;
    return (c == 2) ? g * 3 : pg * 3 + c + 1;
  endfunction

  function automatic bit expClk(int i);
    int code = mClk[i];
    if (code == 0) return clkPin[i];
    if (code >= 1 && code <= 5) return tickAt(code);
    if (code == 6) return ctrOut[nb1(i)];
    if (code == 7) return extClk[i / 3];
    if (!enhanced) return 0;
    if (code == 8 || code == 11) return 1;
    if (code == 10) return patPresent;
    return 0;
  endfunction

  function automatic bit expGate(int i);
    int code = mGate[i];
    if (code == 0) return 1;
    if (code == 1) return 0;
    if (code == 2) return gatePin[i];
    if (code == 3) return !ctrOut[nb2(i)];
    if (!enhanced) return 0;
    case (code)
      6: return !gatePin[i];
      7: return ctrOut[nb2(i)];
      8: return patPresent;
      9: return mOcc;
      10: return mGone;
      11: return !patPresent;
      12: return !mOcc;
      13: return !mGone;
      default: return 0;
    endcase
  endfunction

  task automatic compareAll();
    logic [NC-1:0] eC, eG, eCo, eGo;
    logic [4:0] eR;
    for (int i = 0; i < NC; i++) begin
      eC[i] = expClk(i);
      eG[i] = expGate(i);
      eCo[i] = mClk[i] != 0;
      eGo[i] = mGate[i] != 2;
    end
    eR = (addr[2:0] < 6) ? 5'(addr[3] ? mGate[addr[2:0]] : mClk[addr[2:0]]) : 5'd0;
    vectors++;
    if (ctrClk !== eC) begin misses++;
      $display("FAIL R1 clock route cyc=%0d act=%b exp=%b", cyc, ctrClk, eC); end
    if (ctrGate !== eG) begin misses++;
      $display("FAIL R4 gate route cyc=%0d act=%b exp=%b", cyc, ctrGate, eG); end
    if (clkPinOe !== eCo || gatePinOe !== eGo) begin misses++;
      $display("FAIL R7 pin oe act=%b/%b exp=%b/%b", clkPinOe, gatePinOe, eCo, eGo); end
    if (rdata !== eR) begin misses++;
      $display("FAIL R9 readback addr=%0d act=%0d exp=%0d", addr, rdata, eR); end
  endtask

  task automatic step();
    @(negedge clk); #1; compareAll();
  endtask

  task automatic randPins();
    clkPin = NC'($urandom); gatePin = NC'($urandom);
    ctrOut = NC'($urandom); extClk = NG'($urandom);
  endtask

  task automatic wr(input logic [3:0] a, input int v);
    wrEn = 1; addr = a; wdata = 5'(v); step(); wrEn = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; step(); step(); rstN = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int pulses0, pulses1;
    // R10: state during and right after reset
    step(); step();
    rstN = 1; step();

    // R9: write distinct values, read back, unmapped writes ignored
    for (int i = 0; i < NC; i++) begin wr(4'(i), i + 9); wr(4'(8 + i), 20 - i); end
    wr(4'd6, 17); wr(4'd15, 31); wr(4'd7, 3);
    for (int a = 0; a < 16; a++) begin addr = 4'(a); step(); end

    // R1 R3 R6: sweep every clock code in both modes with random stimulus
    for (int m = 0; m < 2; m++) begin
      enhanced = m[0];
      for (int code = 0; code < 32; code++) begin
        for (int i = 0; i < NC; i++) wr(4'(i), code);
        for (int t = 0; t < 12; t++) begin randPins(); patPresent = $urandom; step(); end
      end
    end

    // R4 R5 R6 R8: sweep every gate code in both modes
    for (int m = 0; m < 2; m++) begin
      enhanced = m[0];
      for (int code = 0; code < 32; code++) begin
        for (int i = 0; i < NC; i++) wr(4'(8 + i), code);
        for (int t = 0; t < 12; t++) begin
          randPins(); patPresent = $urandom; patClr = ($urandom % 8) == 0; step();
        end
        patClr = 0;
      end
    end

    // R8: directed pattern sequence with gate codes 9,10 on channels 0,1
    enhanced = 1; patPresent = 0;
    wr(4'd8, 9); wr(4'd9, 10); wr(4'd10, 13);
    patClr = 1; step(); patClr = 0; step();
    patPresent = 1; step(); step();
    if (ctrGate[0] !== 1'b1) begin misses++;
      $display("FAIL R8 occurred latch act=%b exp=1", ctrGate[0]); end
    vectors++;
    patPresent = 0; step(); step();
    if (ctrGate[1] !== 1'b0) begin misses++;
      $display("FAIL R8 gone latch act=%b exp=0", ctrGate[1]); end
    vectors++;
    patPresent = 1; step(); patPresent = 0; step();
    patClr = 1; step(); patClr = 0; step();
    if (ctrGate[1:0] !== 2'b10) begin misses++;
      $display("FAIL R8 clear act=%b exp=10", ctrGate[1:0]); end
    vectors++;

    // R2 R10: fresh reset, then count slow taps over 40000 cycles
    doReset();
    enhanced = 0; clkPin = '0; extClk = '0; ctrOut = '0;
    pulses0 = 0; pulses1 = 0;
    wrEn = 1; addr = 4'd0; wdata = 5'd5;
    @(negedge clk); #1; compareAll();
    addr = 4'd1; wdata = 5'd4;
    @(negedge clk); #1; compareAll();
    wrEn = 0;
    while (cyc < 40000) begin
      step();
      if (ctrClk[0]) pulses0++;
      if (ctrClk[1]) pulses1++;
    end
    vectors++;
    if (pulses0 != 2) begin misses++;
      $display("FAIL R2 1k tap pulses act=%0d exp=2", pulses0); end
    vectors++;
    if (pulses1 != 20) begin misses++;
      $display("FAIL R2 10k tap pulses act=%0d exp=20", pulses1); end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule